// File: doc/BRIEF.md
# Vector Halfword Element Store Unit

This unit executes one instruction of a big-endian processor with 32-bit instructions: the store of a single 16-bit element of a 128-bit vector register. The unit accepts three inputs: the instruction word, the two 64-bit general register operands that the issue stage has already read, and the vector source value. It forms a 32-bit effective address and picks the halfword lane that the address selects. It then presents a write to a quadword-wide memory port on which exactly two byte enables are set.

The unit also keeps one load-reserve reservation, held at a 32-byte granule. A neighbouring load-reserve path sets the reservation. A store that lands in the reserved granule clears it, in the same cycle that the write strobe appears. If the instruction word does not decode as this store, the unit raises a one-cycle illegal flag and performs no write.

Top module: `vec_half_store`

## Requirements
- R1: A word is legal only when bits 31:26 equal 31, bits 10:1 equal 167 and bit 0 is 0 (0x7C00014E with empty register fields). Any other accepted word gives a one-cycle `illegal` pulse and no `wr_strobe`.
- R2: When the RA field (bits 20:16) is 0, the base is the constant zero and `ra_val` is ignored. Otherwise the base is `ra_val`.
- R3: The effective address EA is the low 32 bits of the 64-bit sum of base and `rb_val`. The sum wraps. `wr_qaddr` equals EA with bits 3:0 cleared.
- R4: The lane is EA[3:1], so EA bit 0 has no effect. `wr_be` has bits 2*lane and 2*lane+1 set and no other bit set. Bit k of `wr_be` enables byte offset k of the quadword.
- R5: The stored halfword is `vs_val[127-16*lane -: 16]`, so lane 0 is the most significant halfword. The halfword is replicated into all eight halfword positions of `wr_data`. Byte offset k sits at `wr_data[127-8*k -: 8]`, which places the more significant byte at the lower address.
- R6: An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. Its `wr_strobe` or `illegal` pulse appears for exactly one cycle after that edge. Instructions may follow each other on consecutive cycles.
- R7: Suppose a legal store is taken while `rsv_track_en` is high and the reservation is valid, and the store's EA[31:5] equals the reserved address bits 31:5. Then `rsv_valid` falls in the same cycle that `wr_strobe` rises.
- R8: The reservation stays valid after a store to another granule, after any store made while `rsv_track_en` is low, and after an illegal word.
- R9: While reset is held, `in_ready`, `wr_strobe`, `illegal` and `rsv_valid` are low. `in_ready` is high from the first edge after reset is released.
- R10: A `rsv_set` pulse makes the reservation valid at `rsv_addr` from the next cycle. If a store hits the old reservation on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction |
| instr | input | 32 | Instruction word |
| ra_val | input | 64 | Contents of the register named by RA |
| rb_val | input | 64 | Contents of the register named by RB |
| vs_val | input | 128 | Source vector value |
| rsv_track_en | input | 1 | Reservation tracking enabled |
| rsv_set | input | 1 | Load-reserve sets the reservation |
| rsv_addr | input | 32 | Address of the new reservation |
| rsv_valid | output | 1 | Reservation currently held |
| wr_strobe | output | 1 | One-cycle memory write strobe |
| wr_qaddr | output | 32 | Quadword-aligned write address |
| wr_be | output | 16 | Byte enables, bit k for byte offset k |
| wr_data | output | 128 | Write data, big-endian byte order |
| illegal | output | 1 | One-cycle illegal-instruction flag |

## Verification
The bench sends the RA=0 case with a large garbage value in `ra_val`. A design that reads the register would write to a far-away quadword. It also sends odd addresses, 64-bit sums that wrap and every one of the eight lanes. An off-by-one lane choice, a reversed lane order or a byte swap would show up as a wrong `wr_be` pair or wrong data bytes. Reservation tests cover a hit in the last halfword of a granule, a store to the next granule, a store with tracking disabled, an illegal word, and a set that coincides with a hit. A design with wrong granule bits or wrong priority would drop the reservation or keep it when it should not. Words that differ from the legal encoding by a single field, including the Rc bit, must give `illegal` and never a write.

// File: rtl/vec_half_store.sv
module vec_half_store #(
  parameter int GRAN_LG = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  instr,
  input  logic [63:0]  ra_val,
  input  logic [63:0]  rb_val,
  input  logic [127:0] vs_val,
  input  logic         rsv_track_en,
  input  logic         rsv_set,
  input  logic [31:0]  rsv_addr,
  output logic         rsv_valid,
  output logic         wr_strobe,
  output logic [31:0]  wr_qaddr,
  output logic [15:0]  wr_be,
  output logic [127:0] wr_data,
  output logic         illegal
);
  localparam int GW = 32 - GRAN_LG;

  wire [5:0]  opcd  = instr[31:26];
  wire [4:0]  ra_f  = instr[20:16];
  wire [9:0]  xo    = instr[10:1];
  wire        legal = (opcd == 6'd31) && (xo == 10'd167) && !instr[0];
  wire        accept = in_valid && in_ready;

  wire [63:0] base = (ra_f == 5'd0) ? 64'd0 : ra_val;
  wire [63:0] sum  = base + rb_val;
  wire [31:0] ea   = sum[31:0];
  wire [2:0]  lane = ea[3:1];

  logic [15:0]   half;
  logic [GW-1:0] rsv_a;
  logic          rsv_v;

  always_comb half = vs_val[16*(7 - int'(lane)) +: 16];

  wire hit = rsv_track_en && rsv_v && (ea[31:GRAN_LG] == rsv_a);

  wire unused_bits = ^{instr[25:21], instr[15:11], sum[63:32], ea[0], rsv_addr[GRAN_LG-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      wr_strobe <= 1'b0;
      illegal   <= 1'b0;
      wr_qaddr  <= '0;
      wr_be     <= '0;
      wr_data   <= '0;
      rsv_v     <= 1'b0;
      rsv_a     <= '0;
    end else begin
      in_ready  <= 1'b1;
      wr_strobe <= accept && legal;
      illegal   <= accept && !legal;
      if (accept && legal) begin
        wr_qaddr <= {ea[31:4], 4'd0};
        wr_be    <= 16'h0003 << {lane, 1'b0};
        wr_data  <= {8{half}};
      end
      if (rsv_set) begin
        rsv_v <= 1'b1;
        rsv_a <= rsv_addr[31:GRAN_LG];
      end else if (accept && legal && hit) begin
        rsv_v <= 1'b0;
      end
    end
  end

  assign rsv_valid = rsv_v;
endmodule

module vec_half_store_chk #(
  parameter int GRAN_LG = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                rsv_track_en,
  input logic                rsv_set,
  input logic                rsv_valid,
  input logic                wr_strobe,
  input logic [31:0]         wr_qaddr,
  input logic [15:0]         wr_be,
  input logic                illegal,
  input logic [31-GRAN_LG:0] rsv_a
);
  p_two_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($countones(wr_be) == 2) && ((wr_be & 16'hAAAA) == ((wr_be & 16'h5555) << 1)));

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && illegal));

  p_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe || illegal) |-> $past(in_valid && in_ready));

  p_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && $past(rsv_track_en && rsv_valid && !rsv_set)
     && (wr_qaddr[31:GRAN_LG] == $past(rsv_a))) |-> !rsv_valid);

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && $past(!rsv_set)) |-> (rsv_valid == $past(rsv_valid)));

  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rsv_set) |-> rsv_valid);
endmodule

bind vec_half_store vec_half_store_chk #(.GRAN_LG(GRAN_LG)) chk_i (.*);

// File: tb/vec_half_store_tb_top.sv
module vec_half_store_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, rsv_track_en = 1'b0, rsv_set = 1'b0;
  logic [31:0] instr = '0, rsv_addr = '0;
  logic [63:0] ra_val = '0, rb_val = '0;
  logic [127:0] vs_val = '0;
  logic in_ready, rsv_valid, wr_strobe, illegal;
  logic [31:0] wr_qaddr;
  logic [15:0] wr_be;
  logic [127:0] wr_data;

  always #2 clk = ~clk;

  vec_half_store dut_i (.*);

  typedef struct packed {
    logic st; logic il; logic [31:0] q; logic [15:0] be; logic [127:0] d;
  } exp_t;
  exp_t  sb_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [127:0] VEC = 128'h1112_2324_3536_4748_595A_6B6C_7D7E_8F80;

  function automatic logic [31:0] mk(input int ra, input int rb, input int op = 31,
                                     input int xo = 167, input int rc = 0);
    return {6'(op), 5'd9, 5'(ra), 5'(rb), 10'(xo), 1'(rc)};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic [127:0] v);
    exp_t e;
    logic [63:0] base, s;
    logic [31:0] ea;
    int ln;
    base = (w[20:16] == 5'd0) ? 64'd0 : a;
    s = base + b;
    ea = s[31:0];
    ln = int'(ea[3:1]);
    e.il = !(w[31:26] == 6'd31 && w[10:1] == 10'd167 && w[0] == 1'b0);
    e.st = !e.il;
    e.q  = ea & 32'hFFFF_FFF0;
    e.be = 16'h0;
    e.be[2*ln] = 1'b1;
    e.be[2*ln+1] = 1'b1;
    e.d  = {8{v[127-16*ln -: 16]}};
    sb_q.push_back(e);
    tag_q.push_back(tag);
    instr = w; ra_val = a; rb_val = b; vs_val = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (wr_strobe || illegal)) begin
      if (sb_q.size() == 0) begin
        check("R6 unexpected output", {wr_strobe, illegal}, 2'b00);
      end else begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check({t, " flags"}, {wr_strobe, illegal}, {e.st, e.il});
        if (e.st) begin
          check({t, " addr"}, wr_qaddr, e.q);
          check({t, " be"}, wr_be, e.be);
          check({t, " data"}, wr_data, e.d);
        end
      end
    end
  end

  task automatic set_rsv(input logic [31:0] a);
    rsv_set = 1'b1; rsv_addr = a;
    @(negedge clk);
    rsv_set = 1'b0;
    check("R10 reservation set", rsv_valid, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {in_ready, wr_strobe, illegal, rsv_valid}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", in_ready, 1'b1);

    drive("R3 R4 basic", mk(3, 4), 64'h1000, 64'h26, VEC);
    drive("R4 odd ea", mk(3, 4), 64'h1000, 64'h27, VEC);
    drive("R2 ra zero", mk(0, 4), 64'hDEAD_BEEF_0000_0100, 64'h4000_0008, VEC);
    drive("R3 wrap", mk(5, 6), 64'hFFFF_FFFF_FFFF_FFF0, 64'h24, VEC);
    drive("R3 upper bits", mk(5, 6), 64'h1234_5678_0000_0010, 64'hABCD_0000_8000_0003, VEC);
    for (int i = 0; i < 8; i++)
      drive("R5 lane sweep", mk(1, 2), 64'h5000, 64'(2 * i), VEC);
    drive("R1 bad opcode", mk(1, 2, 30), 64'h0, 64'h0, VEC);
    drive("R1 bad xo", mk(1, 2, 31, 166), 64'h0, 64'h0, VEC);
    drive("R1 rc bit", mk(1, 2, 31, 167, 1), 64'h0, 64'h0, VEC);
    drive("R6 back2back", mk(1, 2), 64'h7000, 64'h0E, ~VEC);
    @(negedge clk);

    rsv_track_en = 1'b1;
    set_rsv(32'h2000);
    drive("R7 hit store", mk(1, 2), 64'h2000, 64'h1F, VEC);
    check("R7 reservation killed", rsv_valid, 1'b0);
    set_rsv(32'h2000);
    drive("R8 next granule", mk(1, 2), 64'h2000, 64'h20, VEC);
    check("R8 other granule keeps", rsv_valid, 1'b1);
    drive("R8 illegal keeps", mk(1, 2, 31, 168), 64'h2000, 64'h4, VEC);
    check("R8 illegal keeps rsv", rsv_valid, 1'b1);
    rsv_track_en = 1'b0;
    drive("R8 tracking off", mk(1, 2), 64'h2000, 64'h4, VEC);
    check("R8 tracking off keeps", rsv_valid, 1'b1);
    rsv_track_en = 1'b1;
    rsv_set = 1'b1; rsv_addr = 32'h3000;
    drive("R10 set with hit", mk(1, 2), 64'h2000, 64'h2, VEC);
    rsv_set = 1'b0;
    check("R10 set wins over kill", rsv_valid, 1'b1);
    drive("R7 hit new rsv", mk(0, 2), 64'h0, 64'h301C, VEC);
    check("R7 new reservation killed", rsv_valid, 1'b0);

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end
endmodule